// File: doc/BRIEF.md
# Fully Associative Tag Directory

This block holds the tag and state side of a small fully associative cache. Each of its lines carries a tag, a valid flag and a modified flag. The tag of a request is compared with every line tag at once. The block reports a hit and the line that hit. It also presents, at all times, the line it would replace on a miss, the tag held there, and whether that line must be written back first.

A lookup that misses fills the proposed victim line with the requested tag on the clock edge. Lines that are not valid are taken first. When every line is valid, the victim is chosen by a replacement policy selected at run time: least recently used, first in first out, least frequently used, or a free-running counter. Separate inputs invalidate a single line or clear every valid flag in one cycle. Data storage and the memory-side interface belong to the surrounding cache.

Top module: `assoc_tag_dir`

## Requirements
- R1: While `req_valid` is high, `hit` is high exactly when a valid line holds `req_tag`, and `hit_idx` then names that line. A line that is not valid never matches.
- R2: A lookup that misses writes `req_tag` into line `vic_idx`, sets its valid flag and clears its modified flag on the edge. `vic_tag` always shows the tag stored in line `vic_idx`.
- R3: While any line is not valid, `vic_idx` is the lowest-numbered line that is not valid, whatever the policy.
- R4: With `policy` = 0 (LRU), every lookup advances all recency counters by one, and the line that was accessed (the hit line or the filled line) restarts at zero. When all lines are valid, the victim is the line with the largest count.
- R5: With `policy` = 1 (FIFO), every fill advances all age counters by one, and the filled line restarts at zero. Hits leave the ages unchanged. When all lines are valid, the victim is the line with the largest age.
- R6: With `policy` = 2 (LFU), a hit advances that line's use counter by one, and a fill sets it to zero. When all lines are valid, the victim is the line with the smallest count.
- R7: With `policy` = 3, the victim is a counter that starts at 0 after reset, advances by one on every clock and wraps from LINES-1 to 0, independent of any request.
- R8: A write lookup (`req_write` high) that hits sets the modified flag of the hit line. `vic_wb` is high exactly when the victim line is valid and modified.
- R9: `inval_valid` clears the valid flag of line `inval_idx` on the edge, overriding a fill of that line in the same cycle. A later lookup of that line's tag misses.
- R10: `flush` clears every valid flag on the edge. A lookup or invalidate in the same cycle has no effect on the lines or the counters.
- R11: Recency, age and use counters saturate at 2^CNT_W-1 and do not wrap. Equal counts are resolved toward the lowest line index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_write | input | 1 | Lookup is a write |
| req_tag | input | TAG_W | Tag presented for lookup |
| policy | input | 2 | Replacement policy: 0 LRU, 1 FIFO, 2 LFU, 3 counter |
| inval_valid | input | 1 | Invalidate one line |
| inval_idx | input | IDX_W | Line to invalidate |
| flush | input | 1 | Clear all valid flags |
| hit | output | 1 | Tag matched a valid line |
| hit_idx | output | IDX_W | Matching line |
| vic_idx | output | IDX_W | Line to be replaced on a miss |
| vic_wb | output | 1 | Victim must be written back |
| vic_tag | output | TAG_W | Tag held in the victim line |

## Verification
Long mixed runs under each policy use a tag range only a little wider than the line count. This keeps the directory full and forces evictions, write hits on lines about to be evicted, and counters that reach saturation and tie. A design that wrapped its counters, broke ties upward, or let hits reorder the FIFO ages would name the wrong victim. Invalidate and flush requests are mixed in, some landing on the line being filled in the same cycle. A design that let the fill win, or acted on a lookup during a flush, would report a hit where a miss is due. Directed steps check that a stale tag misses after an invalidate or a flush, and that a write-back is flagged only for a valid modified victim.

// File: rtl/assoc_tag_dir.sv
module assoc_tag_dir #(
  parameter int LINES = 4,
  parameter int TAG_W = 8,
  parameter int CNT_W = 4,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [1:0]       policy,
  input  logic             inval_valid,
  input  logic [IDX_W-1:0] inval_idx,
  input  logic             flush,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [IDX_W-1:0] vic_idx,
  output logic             vic_wb,
  output logic [TAG_W-1:0] vic_tag
);

  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

  logic [LINES-1:0] valid, dirty, match;
  logic [TAG_W-1:0] tags  [LINES];
  logic [CNT_W-1:0] recent[LINES];
  logic [CNT_W-1:0] age   [LINES];
  logic [CNT_W-1:0] uses  [LINES];
  logic [IDX_W-1:0] rnd;
  logic [IDX_W-1:0] free_idx, old_idx, fifo_idx, rare_idx;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return (c == CMAX) ? c : c + 1'b1;
  endfunction

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      match[i] = valid[i] && (tags[i] == req_tag);
      if (match[i]) hit_idx = i[IDX_W-1:0];
    end
  end
  assign hit = req_valid && (|match);

  always_comb begin
    free_idx = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (!valid[i]) free_idx = i[IDX_W-1:0];
    old_idx  = '0;
    fifo_idx = '0;
    rare_idx = '0;
    for (int i = 1; i < LINES; i++) begin
      if (recent[i] > recent[old_idx]) old_idx  = i[IDX_W-1:0];
      if (age[i]    > age[fifo_idx])   fifo_idx = i[IDX_W-1:0];
      if (uses[i]   < uses[rare_idx])  rare_idx = i[IDX_W-1:0];
    end
    if (!(&valid)) vic_idx = free_idx;
    else begin
      case (policy)
        2'd0:    vic_idx = old_idx;
        2'd1:    vic_idx = fifo_idx;
        2'd2:    vic_idx = rare_idx;
        default: vic_idx = rnd;
      endcase
    end
  end

  assign vic_wb  = valid[vic_idx] && dirty[vic_idx];
  assign vic_tag = tags[vic_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0;
      dirty <= '0;
      rnd   <= '0;
      for (int i = 0; i < LINES; i++) begin
        tags[i]   <= '0;
        recent[i] <= '0;
        age[i]    <= '0;
        uses[i]   <= '0;
      end
    end else begin
      rnd <= (rnd == LAST) ? '0 : rnd + 1'b1;
      if (flush) valid <= '0;
      else begin
        if (req_valid) begin
          for (int i = 0; i < LINES; i++) recent[i] <= bump(recent[i]);
          if (hit) begin
            recent[hit_idx] <= '0;
            uses[hit_idx]   <= bump(uses[hit_idx]);
            if (req_write) dirty[hit_idx] <= 1'b1;
          end else begin
            for (int i = 0; i < LINES; i++) age[i] <= bump(age[i]);
            tags[vic_idx]   <= req_tag;
            valid[vic_idx]  <= 1'b1;
            dirty[vic_idx]  <= 1'b0;
            recent[vic_idx] <= '0;
            age[vic_idx]    <= '0;
            uses[vic_idx]   <= '0;
          end
        end
        if (inval_valid) valid[inval_idx] <= 1'b0;
      end
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R1

  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !(&valid) |-> !valid[vic_idx]); // R3

  AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit && !flush && !inval_valid) |=>
      (valid[$past(vic_idx)] && !dirty[$past(vic_idx)])); // R2

  AST_WB_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    vic_wb |-> (&valid)); // R8

  AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_valid && !flush) |=> !valid[$past(inval_idx)]); // R9

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid == '0)); // R10

endmodule

// File: tb/test_assoc_tag_dir.sv
`timescale 1ns/1ps
module test_assoc_tag_dir;
  localparam int LINES = 4;
  localparam int TAG_W = 8;
  localparam int CNT_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, inval_valid = 0, flush = 0;
  logic [TAG_W-1:0] req_tag = '0;
  logic [1:0] policy = '0;
  logic [1:0] inval_idx = '0;
  logic hit, vic_wb;
  logic [1:0] hit_idx, vic_idx;
  logic [TAG_W-1:0] vic_tag;

  int checks = 0, errors = 0;
  int m_valid[LINES], m_mod[LINES], m_tag[LINES];
  int m_rec[LINES], m_age[LINES], m_use[LINES];
  int m_rnd = 0;

  always #2 clk = ~clk;

  assoc_tag_dir #(.LINES(LINES), .TAG_W(TAG_W), .CNT_W(CNT_W)) i_assoc_tag_dir (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_tag(req_tag), .policy(policy), .inval_valid(inval_valid),
    .inval_idx(inval_idx), .flush(flush), .hit(hit), .hit_idx(hit_idx),
    .vic_idx(vic_idx), .vic_wb(vic_wb), .vic_tag(vic_tag));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int c);
    return (c == CMAX) ? c : c + 1;
  endfunction

  task automatic step(input bit rv, input bit wr, input int tag,
                      input bit iv, input int ii, input bit fl,
                      output bit got_hit);
    int e_hit, e_hidx, e_vic, full;
    string vl;
    req_valid = rv; req_write = wr; req_tag = tag[TAG_W-1:0];
    inval_valid = iv; inval_idx = ii[1:0]; flush = fl;
    #1;
    e_hit = 0; e_hidx = 0;
    for (int i = 0; i < LINES; i++)
      if (m_valid[i] != 0 && m_tag[i] == tag) begin e_hit = 1; e_hidx = i; end
    if (!rv) e_hit = 0;
    full = 1; e_vic = 0;
    for (int i = LINES - 1; i >= 0; i--) if (m_valid[i] == 0) begin full = 0; e_vic = i; end
    vl = "R3";
    if (full != 0) begin
      case (policy)
        2'd0: begin vl = "R4/R11";
          for (int i = 1; i < LINES; i++) if (m_rec[i] > m_rec[e_vic]) e_vic = i; end
        2'd1: begin vl = "R5/R11";
          for (int i = 1; i < LINES; i++) if (m_age[i] > m_age[e_vic]) e_vic = i; end
        2'd2: begin vl = "R6/R11";
          for (int i = 1; i < LINES; i++) if (m_use[i] < m_use[e_vic]) e_vic = i; end
        default: begin vl = "R7"; e_vic = m_rnd; end
      endcase
    end
    chk("R1 hit", int'(hit), e_hit);
    if (e_hit != 0) chk("R1 hit_idx", int'(hit_idx), e_hidx);
    chk(vl, int'(vic_idx), e_vic);
    chk("R8 vic_wb", int'(vic_wb), (m_valid[e_vic] != 0 && m_mod[e_vic] != 0) ? 1 : 0);
    chk("R2 vic_tag", int'(vic_tag), m_tag[e_vic]);
    got_hit = (e_hit != 0);
    m_rnd = (m_rnd == LINES - 1) ? 0 : m_rnd + 1;
    if (fl) begin
      for (int i = 0; i < LINES; i++) m_valid[i] = 0;
    end else begin
      if (rv) begin
        for (int i = 0; i < LINES; i++) m_rec[i] = sat(m_rec[i]);
        if (e_hit != 0) begin
          m_rec[e_hidx] = 0;
          m_use[e_hidx] = sat(m_use[e_hidx]);
          if (wr) m_mod[e_hidx] = 1;
        end else begin
          for (int i = 0; i < LINES; i++) m_age[i] = sat(m_age[i]);
          m_tag[e_vic] = tag; m_valid[e_vic] = 1; m_mod[e_vic] = 0;
          m_rec[e_vic] = 0; m_age[e_vic] = 0; m_use[e_vic] = 0;
        end
      end
      if (iv) m_valid[ii] = 0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit h;
    for (int i = 0; i < LINES; i++) begin
      m_valid[i] = 0; m_mod[i] = 0; m_tag[i] = 0;
      m_rec[i] = 0; m_age[i] = 0; m_use[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state: empty directory, victim line 0, no write-back
    step(0, 0, 0, 0, 0, 0, h);
    // R2: fill then hit; R8: write hit marks line modified
    step(1, 0, 9, 0, 0, 0, h);
    step(1, 1, 9, 0, 0, 0, h);
    chk("R2 refill hit", int'(h), 1);
    // R9: invalidate line 0 (holds tag 9), then lookup misses
    step(0, 0, 0, 1, 0, 0, h);
    step(1, 0, 9, 0, 0, 0, h);
    chk("R9 stale tag", int'(h), 0);
    // R10: flush with a lookup in the same cycle
    step(1, 0, 4, 0, 0, 1, h);
    step(1, 0, 9, 0, 0, 0, h);
    chk("R10 after flush", int'(h), 0);
    for (int p = 0; p < 4; p++) begin
      policy = p[1:0];
      step(0, 0, 0, 0, 0, 1, h);
      for (int n = 0; n < 3000; n++) begin
        int r;
        r = $urandom % 100;
        step(r < 85, ($urandom % 3) == 0, $urandom % 7,
             r >= 95, $urandom % LINES, r == 99, h);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule